// File: doc/BRIEF.md
# Serial Boot Download Engine

This block runs a lockstep byte protocol that loads a program image into memory after reset. In its first cycle out of reset it samples a host-detect pin. If the pin sits at its idle level, the block does not download anything. It raises `done_o` at once and reports a fixed default start address.

If a host drives the pin away from its idle level, the block sends an acknowledge byte. It then takes in a header of configuration, load-address and length fields. Every byte it receives gets one response byte, and the response to each header byte is the header byte that came before it. After the header comes a separator byte, then the payload. Each payload byte is written to memory at a rising address and is acknowledged. The last payload byte is answered with an end code instead.

When the download completes, the block presents the received load address as the start address. A protocol violation locks the block in an error state until the next reset.

Top module: `boot_dl_engine`

## Requirements
- R1: When `host_det_i` equals `DET_IDLE` in the first cycle after reset, `done_o` rises and `start_addr_o` equals `DEF_START`. No receive byte is read and no transmit byte is sent.
- R2: When a host is detected, the first transmitted byte is ACK (0x06), and it is sent before any receive byte is read.
- R3: The header is `CFG_BYTES` configuration bytes, then `ADDR_BYTES` address bytes, then `LEN_BYTES` length bytes. Header byte 0 is answered with ACK, and header byte i (i>0) is answered with header byte i-1.
- R4: `cfg_o` holds configuration byte k in bits [8k+7:8k]. The block does not interpret these bytes.
- R5: The byte after the header must be 0x7e, and it is answered with the last length byte. Any other value there sends the block to the error state without a response.
- R6: The load address and the length are sent most significant byte first. Payload byte k is written with `mem_we_o` at address load+k (modulo 2^(8*ADDR_BYTES)), with `mem_wdata_o` equal to the byte. Exactly `length` writes occur.
- R7: Every payload byte except the last is answered with ACK (0x06). The last is answered with END (0x04).
- R8: After the last payload byte, `done_o` rises together with the END transmission and `start_addr_o` equals the load address. Both hold until reset.
- R9: A length of zero (checked when the last length byte arrives) or a bad separator raises `err_o`. After that, no byte is read, sent or written until reset, and `done_o` stays low.
- R10: `rx_rd_o` pulses only on a byte for which `rx_full_i` was seen, and each pulse consumes that byte. `tx_wr_o` pulses only after `tx_empty_i` was seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_det_i | input | 1 | Host-detect pin, sampled in the first cycle after reset |
| rx_data_i | input | 8 | Received byte |
| rx_full_i | input | 1 | Receive register holds an unread byte |
| rx_rd_o | output | 1 | One-cycle read pulse; clears the receive-full flag |
| tx_empty_i | input | 1 | Transmit register can accept a byte |
| tx_data_o | output | 8 | Byte to transmit |
| tx_wr_o | output | 1 | One-cycle transmit write pulse |
| mem_we_o | output | 1 | Payload write enable |
| mem_addr_o | output | 8*ADDR_BYTES | Payload write address |
| mem_wdata_o | output | 8 | Payload write data |
| cfg_o | output | 8*CFG_BYTES | Latched configuration bytes |
| done_o | output | 1 | Boot decision made, start address valid |
| err_o | output | 1 | Locked in the error state |
| start_addr_o | output | 8*ADDR_BYTES | Address to start execution from |

## Verification
The bench builds the block with three configuration bytes, a four-byte address, a two-byte length, a default start of 0x2000 and an idle-high detect pin. The odd configuration count places the address and length fields at header positions that are not word aligned, so a wrong field offset shows up in both the echoes and the write addresses. The two-byte length allows a transfer of 256 bytes, whose low length byte is zero while the high byte is not, to be told apart from a true zero length. Single-byte payloads, an address that wraps past the top of the address space, and random stalls on the transmit side are also within reach.

// File: rtl/bde_pkg.sv
package bde_pkg;
  localparam logic [7:0] ACK_CODE  = 8'h06;
  localparam logic [7:0] END_CODE  = 8'h04;
  localparam logic [7:0] MARK_CODE = 8'h7e;

  typedef enum logic [2:0] {
    ST_PROBE,
    ST_SEND,
    ST_HDR,
    ST_MARK,
    ST_DATA,
    ST_DONE,
    ST_LOCK
  } bde_state_e;
endpackage

// File: rtl/bde_hdr_store.sv
// Holds every header byte in one packed register and slices out the fields.
module bde_hdr_store #(
  parameter int CFG_BYTES  = 2,
  parameter int ADDR_BYTES = 4,
  parameter int LEN_BYTES  = 2,
  localparam int HDR_BYTES = CFG_BYTES + ADDR_BYTES + LEN_BYTES,
  localparam int IDX_W     = $clog2(HDR_BYTES),
  localparam int CW        = 8 * CFG_BYTES,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int LW        = 8 * LEN_BYTES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [CW-1:0]    cfg_o,
  output logic [AW-1:0]    base_o,
  output logic [LW-1:0]    len_o,
  output logic             len_hi_zero_o
);
  localparam int ADDR_OFS = CFG_BYTES;
  localparam int LEN_OFS  = CFG_BYTES + ADDR_BYTES;

  logic [8*HDR_BYTES-1:0] hdr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
    end else if (cap_i) begin
      hdr_q[8*idx_i +: 8] <= byte_i;
    end
  end

  // configuration bytes keep arrival order, lowest byte first
  for (genvar c = 0; c < CFG_BYTES; c++) begin : g_cfg
    assign cfg_o[8*c +: 8] = hdr_q[8*c +: 8];
  end

  // address and length arrive most significant byte first
  for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addr
    assign base_o[8*(ADDR_BYTES-1-a) +: 8] = hdr_q[8*(ADDR_OFS+a) +: 8];
  end

  for (genvar l = 0; l < LEN_BYTES; l++) begin : g_len
    assign len_o[8*(LEN_BYTES-1-l) +: 8] = hdr_q[8*(LEN_OFS+l) +: 8];
  end

  // all length bytes other than the final one are zero
  always_comb begin
    len_hi_zero_o = 1'b1;
    for (int k = 0; k < LEN_BYTES - 1; k++) begin
      if (hdr_q[8*(LEN_OFS+k) +: 8] != 8'h00) len_hi_zero_o = 1'b0;
    end
  end
endmodule

// File: rtl/bde_wr_port.sv
// Registered payload write port: address is base plus running offset.
module bde_wr_port #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] off_i,
  input  logic [7:0]    data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= stb_i;
      if (stb_i) begin
        addr_o <= base_i + AW'(off_i);
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/boot_dl_engine.sv
module boot_dl_engine
  import bde_pkg::*;
#(
  parameter int                      CFG_BYTES  = 2,
  parameter int                      ADDR_BYTES = 4,
  parameter int                      LEN_BYTES  = 2,
  parameter logic                    DET_IDLE   = 1'b1,
  parameter logic [8*ADDR_BYTES-1:0] DEF_START  = 'h4000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      host_det_i,
  input  logic [7:0]                rx_data_i,
  input  logic                      rx_full_i,
  output logic                      rx_rd_o,
  input  logic                      tx_empty_i,
  output logic [7:0]                tx_data_o,
  output logic                      tx_wr_o,
  output logic                      mem_we_o,
  output logic [8*ADDR_BYTES-1:0]   mem_addr_o,
  output logic [7:0]                mem_wdata_o,
  output logic [8*CFG_BYTES-1:0]    cfg_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [8*ADDR_BYTES-1:0]   start_addr_o
);
  localparam int HDR_BYTES = CFG_BYTES + ADDR_BYTES + LEN_BYTES;
  localparam int IDX_W     = $clog2(HDR_BYTES);
  localparam int AW        = 8 * ADDR_BYTES;
  localparam int LW        = 8 * LEN_BYTES;

  bde_state_e       st_q, ret_q;
  logic [IDX_W-1:0] idx_q;
  logic [LW-1:0]    cnt_q;
  logic [7:0]       prev_q, tx_q;
  logic             rd_q, txw_q, done_q, err_q;
  logic [AW-1:0]    start_q;

  logic [AW-1:0]    base;
  logic [LW-1:0]    len;
  logic             hi_zero;
  logic             take, cap, wr_stb, last_hdr, len_zero, last_pay;

  assign take     = rx_full_i && (st_q == ST_HDR || st_q == ST_MARK || st_q == ST_DATA);
  assign cap      = rx_full_i && (st_q == ST_HDR);
  assign wr_stb   = rx_full_i && (st_q == ST_DATA);
  assign last_hdr = (idx_q == IDX_W'(HDR_BYTES - 1));
  assign len_zero = hi_zero && (rx_data_i == 8'h00);
  assign last_pay = (cnt_q == len - LW'(1));

  bde_hdr_store #(
    .CFG_BYTES (CFG_BYTES),
    .ADDR_BYTES(ADDR_BYTES),
    .LEN_BYTES (LEN_BYTES)
  ) u_hdr (
    .clk          (clk),
    .rst          (rst),
    .cap_i        (cap),
    .idx_i        (idx_q),
    .byte_i       (rx_data_i),
    .cfg_o        (cfg_o),
    .base_o       (base),
    .len_o        (len),
    .len_hi_zero_o(hi_zero)
  );

  bde_wr_port #(
    .AW(AW),
    .LW(LW)
  ) u_wr (
    .clk   (clk),
    .rst   (rst),
    .stb_i (wr_stb),
    .base_i(base),
    .off_i (cnt_q),
    .data_i(rx_data_i),
    .we_o  (mem_we_o),
    .addr_o(mem_addr_o),
    .data_o(mem_wdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_PROBE;
      ret_q   <= ST_HDR;
      idx_q   <= '0;
      cnt_q   <= '0;
      prev_q  <= '0;
      tx_q    <= '0;
      rd_q    <= 1'b0;
      txw_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
    end else begin
      rd_q  <= take;
      txw_q <= 1'b0;
      case (st_q)
        ST_PROBE: begin
          if (host_det_i != DET_IDLE) begin
            tx_q  <= ACK_CODE;
            ret_q <= ST_HDR;
            st_q  <= ST_SEND;
          end else begin
            done_q  <= 1'b1;
            start_q <= DEF_START;
            st_q    <= ST_DONE;
          end
        end
        ST_SEND: begin
          if (tx_empty_i) begin
            txw_q <= 1'b1;
            st_q  <= ret_q;
            if (ret_q == ST_DONE) begin
              done_q  <= 1'b1;
              start_q <= base;
            end
          end
        end
        ST_HDR: begin
          if (rx_full_i) begin
            prev_q <= rx_data_i;
            tx_q   <= (idx_q == '0) ? ACK_CODE : prev_q;
            if (last_hdr) begin
              if (len_zero) begin
                err_q <= 1'b1;
                st_q  <= ST_LOCK;
              end else begin
                ret_q <= ST_MARK;
                st_q  <= ST_SEND;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              ret_q <= ST_HDR;
              st_q  <= ST_SEND;
            end
          end
        end
        ST_MARK: begin
          if (rx_full_i) begin
            if (rx_data_i != MARK_CODE) begin
              err_q <= 1'b1;
              st_q  <= ST_LOCK;
            end else begin
              tx_q  <= prev_q;
              cnt_q <= '0;
              ret_q <= ST_DATA;
              st_q  <= ST_SEND;
            end
          end
        end
        ST_DATA: begin
          if (rx_full_i) begin
            if (last_pay) begin
              tx_q  <= END_CODE;
              ret_q <= ST_DONE;
            end else begin
              tx_q  <= ACK_CODE;
              cnt_q <= cnt_q + LW'(1);
              ret_q <= ST_DATA;
            end
            st_q <= ST_SEND;
          end
        end
        ST_DONE, ST_LOCK: begin
        end
        default: begin
          err_q <= 1'b1;
          st_q  <= ST_LOCK;
        end
      endcase
    end
  end

  assign rx_rd_o      = rd_q;
  assign tx_wr_o      = txw_q;
  assign tx_data_o    = tx_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign start_addr_o = start_q;
endmodule

// File: rtl/bde_checker.sv
module bde_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_full_i,
  input logic          rx_rd_o,
  input logic          tx_empty_i,
  input logic          tx_wr_o,
  input logic          mem_we_o,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] start_addr_o
);
  AST_RD_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_rd_o |-> $past(rx_full_i)); // R10
  AST_TX_AFTER_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_wr_o |-> $past(tx_empty_i)); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R9
  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (err_o && $past(err_o)) |-> !(rx_rd_o || tx_wr_o || mem_we_o)); // R9
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o)); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && $stable(start_addr_o))); // R8
  AST_WE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> rx_rd_o); // R6
endmodule

bind boot_dl_engine bde_checker #(.AW(8 * ADDR_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_full_i   (rx_full_i),
  .rx_rd_o     (rx_rd_o),
  .tx_empty_i  (tx_empty_i),
  .tx_wr_o     (tx_wr_o),
  .mem_we_o    (mem_we_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .start_addr_o(start_addr_o)
);

// File: tb/boot_dl_engine_tb_top.sv
`timescale 1ns/100ps
module boot_dl_engine_tb_top;
  localparam int CFG_N = 3;
  localparam int HDR_N = CFG_N + 4 + 2;
  localparam logic [31:0] DEF_ADDR = 32'h0000_2000;
  localparam logic [7:0] ACK = 8'h06, ENDC = 8'h04, MARK = 8'h7e;

  logic clk = 1'b0, rst = 1'b1, host_det = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic rx_full, rx_rd, tx_empty = 1'b1, tx_wr, mem_we, done, err;
  logic [7:0] tx_data, mem_wdata;
  logic [31:0] mem_addr, start_addr;
  logic [8*CFG_N-1:0] cfg;

  int push_cnt = 0, pop_cnt = 0;
  int rd_cnt = 0, tx_cnt = 0, wr_cnt = 0, first_tx_rd = -1, viol = 0, tx_hold = 0;
  logic [7:0]  tx_log [0:1023];
  logic [31:0] wa_log [0:1023];
  logic [7:0]  wd_log [0:1023];
  int checks = 0, errs = 0;

  assign rx_full = (push_cnt != pop_cnt);

  always #2.5 clk = ~clk;

  boot_dl_engine #(
    .CFG_BYTES(CFG_N), .ADDR_BYTES(4), .LEN_BYTES(2),
    .DET_IDLE(1'b1), .DEF_START(DEF_ADDR)
  ) dut_i (
    .clk(clk), .rst(rst), .host_det_i(host_det),
    .rx_data_i(rx_data), .rx_full_i(rx_full), .rx_rd_o(rx_rd),
    .tx_empty_i(tx_empty), .tx_data_o(tx_data), .tx_wr_o(tx_wr),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .cfg_o(cfg), .done_o(done), .err_o(err), .start_addr_o(start_addr)
  );

  // peripheral models, evaluated away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      pop_cnt = push_cnt; rd_cnt = 0; tx_cnt = 0; wr_cnt = 0;
      first_tx_rd = -1; tx_empty = 1'b1; tx_hold = 0;
    end else begin
      if (rx_rd) begin
        if (!rx_full) viol++;
        pop_cnt++; rd_cnt++;
      end
      if (tx_wr) begin
        if (!tx_empty) viol++;
        if (tx_cnt == 0) first_tx_rd = rd_cnt;
        if (tx_cnt < 1024) tx_log[tx_cnt] = tx_data;
        tx_cnt++;
        tx_empty = 1'b0;
        tx_hold = $urandom_range(0, 3);
      end else if (!tx_empty) begin
        if (tx_hold == 0) tx_empty = 1'b1; else tx_hold--;
      end
      if (mem_we) begin
        if (wr_cnt < 1024) begin wa_log[wr_cnt] = mem_addr; wd_log[wr_cnt] = mem_wdata; end
        wr_cnt++;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    while (push_cnt != pop_cnt) @(negedge clk);
    rx_data = b;
    push_cnt++;
  endtask

  task automatic do_reset(input bit host);
    @(negedge clk);
    host_det = host ? 1'b0 : 1'b1;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // header image: config bytes, address MSB first, length MSB first
  function automatic logic [7:0] hdr_byte(input int i, input logic [8*CFG_N-1:0] c,
                                          input logic [31:0] a, input logic [15:0] l);
    if (i < CFG_N) return c[8*i +: 8];
    if (i < CFG_N + 4) return a[8*(3-(i-CFG_N)) +: 8];
    return l[8*(1-(i-CFG_N-4)) +: 8];
  endfunction

  function automatic logic [7:0] exp_hdr_reply(input int i, input logic [8*CFG_N-1:0] c,
                                               input logic [31:0] a, input logic [15:0] l);
    return (i == 0) ? ACK : hdr_byte(i - 1, c, a, l);
  endfunction

  task automatic good_run(input logic [31:0] a, input logic [15:0] l);
    logic [8*CFG_N-1:0] c;
    logic [7:0] pay [0:511];
    int bad;
    for (int k = 0; k < CFG_N; k++) c[8*k +: 8] = 8'($urandom);
    for (int k = 0; k < l; k++) pay[k] = 8'($urandom);
    do_reset(1'b1);
    for (int i = 0; i < HDR_N; i++) push(hdr_byte(i, c, a, l));
    push(MARK);
    for (int k = 0; k < l; k++) push(pay[k]);
    for (int i = 0; i < 4000 && !done && !err; i++) @(negedge clk);
    idle(2);
    chk("R2", "first tx is ACK", tx_log[0], ACK);
    chk("R2", "reads before first tx", first_tx_rd, 0);
    bad = 0;
    for (int i = 0; i < HDR_N; i++)
      if (tx_log[1+i] != exp_hdr_reply(i, c, a, l)) bad++;
    chk("R3", "header replies wrong", bad, 0);
    chk("R5", "marker reply", tx_log[1+HDR_N], hdr_byte(HDR_N-1, c, a, l));
    bad = 0;
    for (int k = 0; k < l; k++)
      if (tx_log[2+HDR_N+k] != ((k == l - 1) ? ENDC : ACK)) bad++;
    chk("R7", "payload replies wrong", bad, 0);
    chk("R7", "tx count", tx_cnt, 2 + HDR_N + l);
    chk("R6", "write count", wr_cnt, l);
    bad = 0;
    for (int k = 0; k < l; k++)
      if (wa_log[k] != a + 32'(k) || wd_log[k] != pay[k]) bad++;
    chk("R6", "write addr/data wrong", bad, 0);
    chk("R4", "cfg", cfg, c);
    chk("R8", "done", done, 1);
    chk("R8", "start address", start_addr, a);
    chk("R9", "no error on good run", err, 0);
    idle(5);
    chk("R8", "start address held", start_addr, a);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // reset state
    host_det = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "reset rd", rx_rd, 0);
    chk("R1", "reset tx", tx_wr, 0);
    chk("R1", "reset we", mem_we, 0);
    chk("R1", "reset done", done, 0);
    chk("R9", "reset err", err, 0);
    chk("R8", "reset start", start_addr, 0);
    chk("R4", "reset cfg", cfg, 0);

    // no host: default start, nothing consumed or sent
    do_reset(1'b0);
    push(8'h55);
    idle(20);
    chk("R1", "done without host", done, 1);
    chk("R1", "default start", start_addr, DEF_ADDR);
    chk("R1", "no reads", rd_cnt, 0);
    chk("R1", "no tx", tx_cnt, 0);
    chk("R1", "byte still pending", rx_full, 1);

    // directed corners
    good_run(32'h1000_0000, 16'd1);
    good_run(32'hFFFF_FFFE, 16'd5);
    good_run(32'h0003_0000, 16'd256);
    // random transfers
    for (int r = 0; r < 6; r++) good_run($urandom, 16'($urandom_range(2, 24)));

    // bad separator
    begin
      logic [8*CFG_N-1:0] c = 24'hA1B2C3;
      do_reset(1'b1);
      for (int i = 0; i < HDR_N; i++) push(hdr_byte(i, c, 32'h0000_8000, 16'd5));
      push(8'h55);
      idle(30);
      chk("R5", "bad marker err", err, 1);
      chk("R9", "bad marker no done", done, 0);
      chk("R5", "no marker reply", tx_cnt, 1 + HDR_N);
      chk("R9", "reads at lock", rd_cnt, HDR_N + 1);
      push(8'h11);
      idle(30);
      chk("R9", "locked no read", rd_cnt, HDR_N + 1);
      chk("R9", "locked no tx", tx_cnt, 1 + HDR_N);
      chk("R9", "locked no write", wr_cnt, 0);
      chk("R9", "byte left pending", rx_full, 1);
      chk("R9", "err held", err, 1);
    end

    // zero length
    begin
      logic [8*CFG_N-1:0] c = 24'h010203;
      do_reset(1'b1);
      for (int i = 0; i < HDR_N; i++) push(hdr_byte(i, c, 32'h0000_9000, 16'd0));
      idle(30);
      chk("R9", "zero length err", err, 1);
      chk("R9", "zero length tx count", tx_cnt, HDR_N);
      chk("R9", "zero length reads", rd_cnt, HDR_N);
      push(MARK);
      idle(30);
      chk("R9", "zero length locked", rd_cnt, HDR_N);
      chk("R9", "zero length no done", done, 0);
    end

    chk("R10", "handshake violations", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule